// File: doc/BRIEF.md
# Battery charge safety timer

This block supervises how long a battery charger may run. It counts ticks of a slow time base while the charger reports an active phase. Prequalification has its own short limit. Full-rate and constant-voltage charging share one total limit, and the count carries on from the time already spent in prequalification. When a limit is reached the block sets a timeout flag that stays set until the timer is restarted. It emits a one-cycle interrupt pulse, and the charger stops while the flag is high.

Restart events are detected from the levels of the charger's status inputs:

- power arriving on either supply input;
- a swap of the active supply source;
- a re-enable of the charger;
- the end of thermal shutdown;
- the end of a battery-temperature fault while the charger is enabled;
- the end of USB suspend while charging from USB.

The block also provides charge maintenance. A fully charged battery that sags below the restart threshold raises a one-cycle charge-restart request and restarts the timer. A 2-bit code tells the external comparator which restart threshold goes with the selected termination voltage.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, timeout_o, irq_o and restart_req_o are 0 and the elapsed count is zero.
- R2: With phase_i = 1 (prequalification), chg_en_i = 1 and no timeout, each tick_i advances the count by one. On the tick that brings the count to PREQ_HOURS*TICKS_PER_HOUR, timeout_o becomes 1, and irq_o is 1 for exactly that one cycle.
- R3: With phase_i = 2 (full rate) or 3 (constant voltage), the count continues from its prequalification value. timeout_o sets on the tick that brings the total to TOTAL_HOURS*TICKS_PER_HOUR, with the same one-cycle irq_o pulse.
- R4: The count does not change in cycles without tick_i, nor while phase_i = 0 (paused).
- R5: Once set, timeout_o stays 1, and irq_o stays 0, until a restart event. No counting happens in that time.
- R6: A rising edge of (usb_pwr_i OR adp_pwr_i) restarts the timer. A change of src_usb_i while power was present in both the previous and the current cycle also restarts it. A restart clears the count and timeout_o.
- R7: A rising edge of chg_en_i restarts the timer.
- R8: A falling edge of tsd_i restarts the timer. A falling edge of btemp_bad_i restarts it only while chg_en_i = 1.
- R9: A falling edge of usb_susp_i restarts the timer only while src_usb_i = 1 and usb_pwr_i = 1.
- R10: When batt_full_i, chg_en_i, below_rst_i and supply presence all become true together, the timer restarts in that cycle. restart_req_o is 1 for the single cycle after that edge.
- R11: thr_sel_o maps vterm_sel_i as follows: 0 (4.1 V) gives 0 (3.9 V); 1 (4.2 V) gives 1 (4.0 V); 2 (4.38 V) gives 2 (4.2 V). The reserved code 3 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick |
| phase_i | input | 2 | Charge phase: 0 paused, 1 prequal, 2 full rate, 3 constant voltage |
| chg_en_i | input | 1 | Charger enable bit |
| usb_pwr_i | input | 1 | Valid power on USB input |
| adp_pwr_i | input | 1 | Valid power on adapter input |
| src_usb_i | input | 1 | Active source: 1 USB, 0 adapter |
| tsd_i | input | 1 | Thermal shutdown active |
| btemp_bad_i | input | 1 | Battery temperature out of range |
| usb_susp_i | input | 1 | USB suspend active |
| batt_full_i | input | 1 | Battery charged, charger idle in maintenance |
| below_rst_i | input | 1 | Battery below restart threshold (comparator) |
| vterm_sel_i | input | 2 | Termination voltage select |
| timeout_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | One-cycle interrupt on timeout |
| restart_req_o | output | 1 | One-cycle charge-restart request |
| thr_sel_o | output | 2 | Restart-threshold select for the comparator |

## Verification
The bench builds the block with TICKS_PER_HOUR = 4, PREQ_HOURS = 1 and TOTAL_HOURS = 10. The limits are then 4 and 40 ticks, so every timeout and every restart path can be reached in a few hundred cycles. With a 4-tick prequalification budget, the bench can prove that a restart happened: it advances three ticks, triggers the event, and shows that three more ticks do not time out. The 40-tick total shows that the main phase carries on from the prequalification count rather than starting again.

// File: rtl/chg_timer_pkg.sv
// Shared encodings for the charge safety timer.
// Assumes the charger drives the phase code and the termination select directly.
package chg_timer_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_PREQ  = 2'd1,
        PH_RATE  = 2'd2,
        PH_CV    = 2'd3
    } chg_phase_e;

    typedef enum logic [1:0] {
        TERM_4V10 = 2'd0,
        TERM_4V20 = 2'd1,
        TERM_4V38 = 2'd2,
        TERM_RSVD = 2'd3
    } term_sel_e;

    typedef enum logic [1:0] {
        THR_3V90 = 2'd0,
        THR_4V00 = 2'd1,
        THR_4V20 = 2'd2
    } thr_sel_e;

endpackage

// File: rtl/chg_restart_events.sv
// Detects the restart events from the level inputs and issues the maintenance restart request.
// Assumes the inputs are already synchronous to clk. Previous-value registers clear to 0,
// so power that is present at reset release produces one harmless restart.
module chg_restart_events (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_en_i,
    input  logic usb_pwr_i,
    input  logic adp_pwr_i,
    input  logic src_usb_i,
    input  logic tsd_i,
    input  logic btemp_bad_i,
    input  logic usb_susp_i,
    input  logic batt_full_i,
    input  logic below_rst_i,
    output logic restart_o,
    output logic restart_req_o
);
    logic pwr_any, pwr_q, src_q, en_q, tsd_q, btemp_q, susp_q, maint_q, req_q;
    logic ev_power, ev_swap, ev_enable, ev_tsd, ev_temp, ev_susp, maint, ev_maint;

    // Qualify each edge against the conditions under which it counts as a restart.
    always_comb begin
        pwr_any   = usb_pwr_i | adp_pwr_i;
        ev_power  = pwr_any & ~pwr_q;
        ev_swap   = pwr_any & pwr_q & (src_usb_i ^ src_q);
        ev_enable = chg_en_i & ~en_q;
        ev_tsd    = ~tsd_i & tsd_q;
        ev_temp   = ~btemp_bad_i & btemp_q & chg_en_i;
        ev_susp   = ~usb_susp_i & susp_q & src_usb_i & usb_pwr_i;
        maint     = batt_full_i & pwr_any & chg_en_i & below_rst_i;
        ev_maint  = maint & ~maint_q;
        restart_o = ev_power | ev_swap | ev_enable | ev_tsd | ev_temp | ev_susp | ev_maint;
    end

    // Hold last-cycle levels for edge detection and register the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q   <= 1'b0;
            src_q   <= 1'b0;
            en_q    <= 1'b0;
            tsd_q   <= 1'b0;
            btemp_q <= 1'b0;
            susp_q  <= 1'b0;
            maint_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            pwr_q   <= pwr_any;
            src_q   <= src_usb_i;
            en_q    <= chg_en_i;
            tsd_q   <= tsd_i;
            btemp_q <= btemp_bad_i;
            susp_q  <= usb_susp_i;
            maint_q <= maint;
            req_q   <= ev_maint;
        end
    end

    assign restart_req_o = req_q;

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |=> !restart_req_o);

    // R7
    enable_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en_i && !en_q) |-> restart_o);

endmodule

// File: rtl/chg_phase_counter.sv
// Elapsed-time counter with a per-phase limit, a sticky timeout flag and an interrupt pulse.
// Assumes tick_i is a one-cycle pulse. A restart has priority over counting.
module chg_phase_counter
    import chg_timer_pkg::*;
#(
    parameter int PREQ_LIMIT  = 3600,
    parameter int TOTAL_LIMIT = 36000,
    parameter int CNT_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] phase_i,
    input  logic       chg_en_i,
    input  logic       restart_i,
    output logic       timeout_o,
    output logic       irq_o
);
    localparam logic [CNT_W-1:0] PREQ_LIM  = CNT_W'(PREQ_LIMIT);
    localparam logic [CNT_W-1:0] TOTAL_LIM = CNT_W'(TOTAL_LIMIT);

    chg_phase_e       ph;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, limit;
    logic             timeout_q, irq_q, step, hit;

    assign ph = chg_phase_e'(phase_i);

    // Decide whether this cycle counts and whether it reaches the phase limit.
    always_comb begin
        step    = tick_i && (ph != PH_PAUSE) && chg_en_i && !timeout_q;
        cnt_nxt = cnt_q + 1'b1;
        limit   = (ph == PH_PREQ) ? PREQ_LIM : TOTAL_LIM;
        hit     = step && (cnt_nxt >= limit);
    end

    // Advance the count, latch the timeout and pulse the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            timeout_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (restart_i) begin
            cnt_q     <= '0;
            timeout_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= hit;
            if (step) cnt_q <= cnt_nxt;
            if (hit) timeout_q <= 1'b1;
        end
    end

    assign timeout_o = timeout_q;
    assign irq_o     = irq_q;

    // R2
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOTAL_LIM);

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_q && !restart_i) |=> (timeout_q && !irq_q && $stable(cnt_q)));

    // R6
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0 && !timeout_q));

endmodule

// File: rtl/chg_thresh_map.sv
// Maps the termination-voltage select to the restart-threshold select for the comparator.
// Assumes the reserved select code behaves like the 4.2 V setting.
module chg_thresh_map
    import chg_timer_pkg::*;
(
    input  logic [1:0] vterm_sel_i,
    output logic [1:0] thr_sel_o
);
    thr_sel_e thr;

    // Translate termination setting to its restart threshold.
    always_comb begin
        case (term_sel_e'(vterm_sel_i))
            TERM_4V10: thr = THR_3V90;
            TERM_4V20: thr = THR_4V00;
            TERM_4V38: thr = THR_4V20;
            default:   thr = THR_4V00;
        endcase
        // R11
        thr_range_chk: assert (thr != 2'd3);
    end

    assign thr_sel_o = thr;

endmodule

// File: rtl/chg_safety_timer.sv
// Top of the charge safety timer: restart event detection, phase-limited counter, threshold map.
// Assumes all inputs are synchronous to clk and tick_i marks one time unit.
module chg_safety_timer #(
    parameter int TICKS_PER_HOUR = 3600,
    parameter int PREQ_HOURS     = 1,
    parameter int TOTAL_HOURS    = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] phase_i,
    input  logic       chg_en_i,
    input  logic       usb_pwr_i,
    input  logic       adp_pwr_i,
    input  logic       src_usb_i,
    input  logic       tsd_i,
    input  logic       btemp_bad_i,
    input  logic       usb_susp_i,
    input  logic       batt_full_i,
    input  logic       below_rst_i,
    input  logic [1:0] vterm_sel_i,
    output logic       timeout_o,
    output logic       irq_o,
    output logic       restart_req_o,
    output logic [1:0] thr_sel_o
);
    localparam int PREQ_LIMIT  = PREQ_HOURS * TICKS_PER_HOUR;
    localparam int TOTAL_LIMIT = TOTAL_HOURS * TICKS_PER_HOUR;
    localparam int CNT_W       = $clog2(TOTAL_LIMIT + 1);

    logic restart;

    chg_restart_events u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .chg_en_i      (chg_en_i),
        .usb_pwr_i     (usb_pwr_i),
        .adp_pwr_i     (adp_pwr_i),
        .src_usb_i     (src_usb_i),
        .tsd_i         (tsd_i),
        .btemp_bad_i   (btemp_bad_i),
        .usb_susp_i    (usb_susp_i),
        .batt_full_i   (batt_full_i),
        .below_rst_i   (below_rst_i),
        .restart_o     (restart),
        .restart_req_o (restart_req_o)
    );

    chg_phase_counter #(
        .PREQ_LIMIT  (PREQ_LIMIT),
        .TOTAL_LIMIT (TOTAL_LIMIT),
        .CNT_W       (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .phase_i   (phase_i),
        .chg_en_i  (chg_en_i),
        .restart_i (restart),
        .timeout_o (timeout_o),
        .irq_o     (irq_o)
    );

    chg_thresh_map u_thresh (
        .vterm_sel_i (vterm_sel_i),
        .thr_sel_o   (thr_sel_o)
    );

    // R10
    req_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> !timeout_o);

endmodule

// File: tb/chg_safety_timer_test.sv
module chg_safety_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] phase_i = 2'd0;
    logic       chg_en_i = 1'b0, usb_pwr_i = 1'b0, adp_pwr_i = 1'b0, src_usb_i = 1'b0;
    logic       tsd_i = 1'b0, btemp_bad_i = 1'b0, usb_susp_i = 1'b0;
    logic       batt_full_i = 1'b0, below_rst_i = 1'b0;
    logic [1:0] vterm_sel_i = 2'd0;
    logic       timeout_o, irq_o, restart_req_o;
    logic [1:0] thr_sel_o;

    int checks = 0;
    int errors = 0;

    chg_safety_timer #(.TICKS_PER_HOUR(4), .PREQ_HOURS(1), .TOTAL_HOURS(10)) uut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n-1 ticks leave timeout low; the n-th sets it with a single irq pulse
    task automatic expect_limit(input int n, input string req);
        for (int i = 1; i < n; i++) do_tick();
        check({req, " before limit"}, timeout_o, 1'b0);
        do_tick();
        check({req, " timeout at limit"}, timeout_o, 1'b1);
        check({req, " irq at limit"}, irq_o, 1'b1);
        @(negedge clk);
        check({req, " irq single cycle"}, irq_o, 1'b0);
    endtask

    task automatic reach_timeout();
        for (int i = 0; i < 50 && !timeout_o; i++) do_tick();
        idle(1);
    endtask

    task automatic toggle_enable();
        chg_en_i = 1'b0;
        idle(1);
        chg_en_i = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        check("R1 timeout", timeout_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);
        check("R1 restart_req", restart_req_o, 1'b0);
    endtask

    task automatic t_prequal();
        usb_pwr_i = 1'b1; src_usb_i = 1'b1; chg_en_i = 1'b1; phase_i = 2'd1;
        idle(2);
        expect_limit(4, "R2");
        repeat (3) do_tick();
        check("R5 timeout held", timeout_o, 1'b1);
        check("R5 no new irq", irq_o, 1'b0);
        toggle_enable();
        check("R7 enable clears", timeout_o, 1'b0);
        expect_limit(4, "R7");
    endtask

    task automatic t_main();
        toggle_enable();
        phase_i = 2'd1;
        repeat (3) do_tick();
        phase_i = 2'd2;
        repeat (20) do_tick();
        phase_i = 2'd3;
        expect_limit(17, "R3");
    endtask

    task automatic t_freeze();
        toggle_enable();
        phase_i = 2'd0;
        repeat (10) do_tick();
        phase_i = 2'd1;
        repeat (3) do_tick();
        idle(10);
        check("R4 no drift", timeout_o, 1'b0);
        do_tick();
        check("R4 one tick left", timeout_o, 1'b1);
        idle(1);
    endtask

    task automatic t_power();
        reach_timeout();
        usb_pwr_i = 1'b0;
        idle(2);
        usb_pwr_i = 1'b1;
        idle(1);
        check("R6 power-on clears", timeout_o, 1'b0);
        repeat (3) do_tick();
        src_usb_i = 1'b0; adp_pwr_i = 1'b1;
        idle(1);
        expect_limit(4, "R6 swap");
    endtask

    task automatic t_thermal();
        reach_timeout();
        tsd_i = 1'b1; idle(2); tsd_i = 1'b0; idle(1);
        check("R8 thermal exit clears", timeout_o, 1'b0);
        reach_timeout();
        btemp_bad_i = 1'b1; idle(2); btemp_bad_i = 1'b0; idle(1);
        check("R8 temp exit enabled clears", timeout_o, 1'b0);
        reach_timeout();
        chg_en_i = 1'b0;
        btemp_bad_i = 1'b1; idle(2); btemp_bad_i = 1'b0; idle(2);
        check("R8 temp exit disabled ignored", timeout_o, 1'b1);
        chg_en_i = 1'b1; idle(1);
    endtask

    task automatic t_suspend();
        src_usb_i = 1'b0;
        idle(1);
        reach_timeout();
        usb_susp_i = 1'b1; idle(2); usb_susp_i = 1'b0; idle(2);
        check("R9 suspend exit on adapter ignored", timeout_o, 1'b1);
        src_usb_i = 1'b1;
        idle(1);
        reach_timeout();
        usb_susp_i = 1'b1; idle(2); usb_susp_i = 1'b0; idle(1);
        check("R9 suspend exit on USB clears", timeout_o, 1'b0);
    endtask

    task automatic t_maint();
        reach_timeout();
        batt_full_i = 1'b0; below_rst_i = 1'b1;
        idle(2);
        check("R10 no request when not full", restart_req_o, 1'b0);
        check("R10 timeout kept", timeout_o, 1'b1);
        below_rst_i = 1'b0; batt_full_i = 1'b1;
        idle(2);
        below_rst_i = 1'b1;
        @(negedge clk);
        check("R10 request pulse", restart_req_o, 1'b1);
        check("R10 timer restarted", timeout_o, 1'b0);
        @(negedge clk);
        check("R10 request single cycle", restart_req_o, 1'b0);
        batt_full_i = 1'b0; below_rst_i = 1'b0;
    endtask

    task automatic t_thresh();
        vterm_sel_i = 2'd0; #1 check("R11 4.1V", thr_sel_o, 2'd0);
        vterm_sel_i = 2'd1; #1 check("R11 4.2V", thr_sel_o, 2'd1);
        vterm_sel_i = 2'd2; #1 check("R11 4.38V", thr_sel_o, 2'd2);
        vterm_sel_i = 2'd3; #1 check("R11 reserved", thr_sel_o, 2'd1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prequal();
        t_main();
        t_freeze();
        t_power();
        t_thermal();
        t_suspend();
        t_maint();
        t_thresh();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule